// File: doc/BRIEF.md
# Paged ROM Bank Selector

This block holds the number of the ROM that is paged into a sixteen-slot ROM window and turns it into chip selects. The CPU writes a paging register at a fixed offset of a small I/O window. The low three bits of the write carry a ROM number, and bit 3 chooses which half of the slot space it applies to. Four slots are not real sockets. Slots 8 and 9 both route to the keyboard, and slots 10 and 11 both route to the BASIC ROM. Every other slot drives its own socket select.

The low half of the slot space has a guard. A write with bit 3 clear moves the selection only when the current slot is outside the keyboard/BASIC group (8 to 11). Software that starts from BASIC or the keyboard therefore takes two steps. First it writes with bit 3 set to land on one of slots 12 to 15. Then it writes again with bit 3 clear and the wanted number 0 to 7. The register cannot be read back, but the current slot number is available as an output for the surrounding decode.

Top module: `rom_page_select`

## Requirements
- R1: A synchronous reset selects slot 10, so `basic_sel` is 1, `kbd_sel` is 0 and `ext_rom_sel` is all zeros.
- R2: A write to the paging offset with data bit 3 = 1 selects slot 8 + n, where n is data bits 2:0. This holds whatever slot was selected before.
- R3: A write to the paging offset with bit 3 = 0 selects slot n (data bits 2:0), provided the current slot is 0 to 7 or 12 to 15.
- R4: A write to the paging offset with bit 3 = 0 while the current slot is 8 to 11 is ignored, and the selection stays unchanged.
- R5: Data bits 7:4 have no effect on the selection.
- R6: Writes to any other offset, and cycles with `wr_en` low, leave the selection unchanged.
- R7: When slot 8 or 9 is selected, `kbd_sel` is 1, `basic_sel` is 0 and `ext_rom_sel` is zero.
- R8: When slot 10 or 11 is selected, `basic_sel` is 1, `kbd_sel` is 0 and `ext_rom_sel` is zero.
- R9: When any other slot s is selected, `ext_rom_sel` has only bit s set, and `kbd_sel` and `basic_sel` are 0. In every state, exactly one of the eighteen select lines is high.
- R10: All outputs are registered. A write sampled at a rising clock edge is visible on `rom_num` and on the selects right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the I/O window |
| wr_addr | input | ADDR_W (4) | Offset within the I/O window |
| wr_data | input | DATA_W (8) | Write data |
| rom_num | output | 4 | Currently selected slot number |
| kbd_sel | output | 1 | Keyboard alias selected (slot 8 or 9) |
| basic_sel | output | 1 | BASIC ROM selected (slot 10 or 11) |
| ext_rom_sel | output | 16 | One-hot socket select; bits 8 to 11 are never set |

## Verification
Each result is due one cycle after its stimulus. A write presented before a rising edge shows up on every output right after that edge, and nothing changes at any other time. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares at the next falling edge. The sweep starts from every slot and applies every data byte. The expected slot and select pattern come from the requirement arithmetic: 8 + n, n, or unchanged.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int SLOT_CNT = 16;
  localparam int SLOT_W = $clog2(SLOT_CNT);
  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t KBD_A   = slot_t'(8);
  localparam slot_t KBD_B   = slot_t'(9);
  localparam slot_t BASIC_A = slot_t'(10);
  localparam slot_t BASIC_B = slot_t'(11);

  // slots 8..11 are aliases that do not map to a socket
  function automatic logic is_alias(input slot_t s);
    return (s == KBD_A) || (s == KBD_B) || (s == BASIC_A) || (s == BASIC_B);
  endfunction
endpackage

// File: rtl/rps_wr_decode.sv
module rps_wr_decode
  import rps_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PAGE_OFFSET = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  slot_t             cur_slot,
  output slot_t             nxt_slot
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(PAGE_OFFSET);

  logic       hit;
  logic       upper;
  logic [2:0] num;

  assign hit   = wr_en && (wr_addr == OFF);
  assign upper = wr_data[3];
  assign num   = wr_data[2:0];

  always_comb begin
    nxt_slot = cur_slot;
    if (hit) begin
      if (upper)
        nxt_slot = {1'b1, num};
      else if (!is_alias(cur_slot))
        nxt_slot = {1'b0, num};
    end
  end
endmodule

// File: rtl/rps_slot_map.sv
module rps_slot_map
  import rps_pkg::*;
(
  input  slot_t               slot,
  output logic                kbd,
  output logic                basic,
  output logic [SLOT_CNT-1:0] ext
);
  assign kbd   = (slot == KBD_A) || (slot == KBD_B);
  assign basic = (slot == BASIC_A) || (slot == BASIC_B);

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_sock
    if (is_alias(slot_t'(g))) begin : g_alias
      assign ext[g] = 1'b0;
    end else begin : g_real
      assign ext[g] = (slot == slot_t'(g));
    end
  end
endmodule

// File: rtl/rom_page_select.sv
module rom_page_select
  import rps_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PAGE_OFFSET = 5,
  parameter int RESET_SLOT  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [SLOT_W-1:0]   rom_num,
  output logic                kbd_sel,
  output logic                basic_sel,
  output logic [SLOT_CNT-1:0] ext_rom_sel
);
  localparam slot_t RST_SLOT = slot_t'(RESET_SLOT);

  slot_t               nxt_slot;
  logic                nxt_kbd;
  logic                nxt_basic;
  logic [SLOT_CNT-1:0] nxt_ext;
  logic                rst_kbd;
  logic                rst_basic;
  logic [SLOT_CNT-1:0] rst_ext;

  rps_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_OFFSET(PAGE_OFFSET)
  ) dec_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_slot(rom_num), .nxt_slot(nxt_slot)
  );

  rps_slot_map map_i (
    .slot(nxt_slot), .kbd(nxt_kbd), .basic(nxt_basic), .ext(nxt_ext)
  );

  rps_slot_map map_rst_i (
    .slot(RST_SLOT), .kbd(rst_kbd), .basic(rst_basic), .ext(rst_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_num     <= RST_SLOT;
      kbd_sel     <= rst_kbd;
      basic_sel   <= rst_basic;
      ext_rom_sel <= rst_ext;
    end else begin
      rom_num     <= nxt_slot;
      kbd_sel     <= nxt_kbd;
      basic_sel   <= nxt_basic;
      ext_rom_sel <= nxt_ext;
    end
  end
endmodule

// File: rtl/rom_page_select_chk.sv
module rom_page_select_chk
  import rps_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PAGE_OFFSET = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [SLOT_W-1:0]   rom_num,
  input logic                kbd_sel,
  input logic                basic_sel,
  input logic [SLOT_CNT-1:0] ext_rom_sel
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(PAGE_OFFSET);

  logic hit;
  assign hit = wr_en && (wr_addr == OFF);

  assert_reset_slot_R1: assert property (@(posedge clk)
    rst |=> (rom_num == 4'd10) && basic_sel);

  assert_upper_write_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && wr_data[3]) |=> (rom_num == {1'b1, $past(wr_data[2:0])}));

  assert_lower_write_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !wr_data[3] && (rom_num[3:2] != 2'b10)) |=> (rom_num == {1'b0, $past(wr_data[2:0])}));

  assert_guarded_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !wr_data[3] && (rom_num[3:2] == 2'b10)) |=> $stable(rom_num));

  assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(rom_num));

  assert_kbd_map_R7: assert property (@(posedge clk) disable iff (rst)
    kbd_sel == (rom_num[3:1] == 3'b100));

  assert_basic_map_R8: assert property (@(posedge clk) disable iff (rst)
    basic_sel == (rom_num[3:1] == 3'b101));

  assert_one_select_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({kbd_sel, basic_sel, ext_rom_sel}) == 1);

  assert_ext_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_rom_sel != '0) |-> ext_rom_sel[rom_num]);
endmodule

bind rom_page_select rom_page_select_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_OFFSET(PAGE_OFFSET)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rom_num(rom_num), .kbd_sel(kbd_sel), .basic_sel(basic_sel),
  .ext_rom_sel(ext_rom_sel)
);

// File: tb/rom_page_select_tb_top.sv
`timescale 1ns/1ps
module rom_page_select_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rom_num;
  logic        kbd_sel;
  logic        basic_sel;
  logic [15:0] ext_rom_sel;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rom_page_select dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_num(rom_num), .kbd_sel(kbd_sel), .basic_sel(basic_sel),
    .ext_rom_sel(ext_rom_sel)
  );

  // one write: inputs set at a falling edge, one rising edge samples them,
  // results compared at the following falling edge (R10)
  task automatic put(input logic [3:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string req, input int exp);
    logic        ek, eb;
    logic [15:0] ee;
    string       mreq;
    ek = (exp == 8) || (exp == 9);
    eb = (exp == 10) || (exp == 11);
    ee = (ek || eb) ? 16'h0 : (16'h1 << exp);
    mreq = ek ? "R7" : (eb ? "R8" : "R9");
    vectors++;
    if (rom_num !== 4'(exp) || kbd_sel !== ek || basic_sel !== eb || ext_rom_sel !== ee) begin
      fails++;
      $display("FAIL %s %s R10: rom=%0d kbd=%b basic=%b ext=%h expected rom=%0d kbd=%b basic=%b ext=%h",
               req, mreq, rom_num, kbd_sel, basic_sel, ext_rom_sel, exp, ek, eb, ee);
    end
  endtask

  // reach a slot from any state: 0x0C lands on 12, which unlocks the low half
  task automatic reach(input int s);
    put(4'd5, 8'h0C);
    if (s >= 8) put(4'd5, 8'(8 | (s - 8)));
    else        put(4'd5, 8'(s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 10);

    // every starting slot against every data byte at the paging offset
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 256; d++) begin
        int    exp;
        string req;
        reach(s);
        if (d[3])                  begin exp = 8 + (d & 7); req = "R2"; end
        else if (s >= 8 && s <= 11) begin exp = s;          req = "R4"; end
        else                        begin exp = d & 7;      req = "R3"; end
        put(4'd5, 8'(d));
        check($sformatf("%s%s", req, (d > 15) ? " R5" : ""), exp);
      end
    end

    // other offsets and a deasserted strobe leave the slot alone (R6)
    for (int s = 0; s < 16; s += 5) begin
      for (int a = 0; a < 16; a++) begin
        if (a == 5) continue;
        reach(s);
        put(4'(a), 8'h0F);
        check("R6 offset", s);
        put(4'(a), 8'h03);
        check("R6 offset", s);
      end
      put(4'd5, 8'h0E, 1'b0);
      check("R6 strobe", s);
    end

    // two-step path out of BASIC: 10 -> 13 -> 2
    put(4'd5, 8'h0A); check("R2", 10);
    put(4'd5, 8'h02); check("R4", 10);
    put(4'd5, 8'h0D); check("R2", 13);
    put(4'd5, 8'h02); check("R3", 2);

    // reset from a non-default slot
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", 10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule